// File: doc/BRIEF.md
# Bus Layer Retry Arbiter

This block governs one independent layer of a shared on-chip bus, for example the request path or the response path. A source port presents an attempt together with its port number. In the same cycle the block decides whether the attempt may use the layer. When the attempt is granted, the caller reports in that cycle whether the destination took it and how many cycles the layer must stay occupied. For an accepted send that is the time to the end of the packet. For a refused send it is the header time.

Ports that are turned away are not polled. They are kept in an ordered waiting list, and each port appears in it at most once. When the occupation time runs out and someone is waiting, the layer enters a one-cycle retry window. In that window it is reserved for the port at the head of the list, and a retry strobe names that port. If the head port does not send in that cycle, it is dropped from the list. The layer then occupies itself for one cycle before the next head is offered the layer. A single-bit outstanding indicator tells a drain controller whether the layer still has work in flight or ports waiting.

Top module: `bus_layer_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, the layer is idle with an empty waiting list: `retry_valid` is 0, `pending` is 0, and `try_grant` is 0 when `try_valid` is 0.
- R2: An attempt made while the layer is idle is granted combinationally in the same cycle, whatever its port number.
- R3: While the layer is occupied every attempt is refused. During the retry window only the port at the head of the waiting list is granted, and any other port is refused.
- R4: A refused port is appended at the tail of the waiting list. A port that is already waiting is not added a second time.
- R5: A granted attempt occupies the layer for `try_hold` cycles, counted from the cycle after the grant. A value of 0 counts as 1. The layer is free again in the cycle after the last occupied cycle.
- R6: When the head port is granted in the retry window and `try_ok` is 1, it is removed from the waiting list.
- R7: A granted attempt with `try_ok` = 0 occupies the layer for `try_hold` cycles. If it came from the head port during the retry window, that port stays at the front of the list. Otherwise the port is appended at the tail.
- R8: When the occupation ends with a non-empty waiting list, `retry_valid` is 1 for exactly the next cycle, and `retry_id` gives the head port.
- R9: If the head port does not send during its retry window, it is dropped from the list. The layer is occupied for one cycle, and the new head, if there is one, sees `retry_valid` in the cycle after that.
- R10: `pending` is 1 whenever the layer is not idle or the waiting list is not empty, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| try_valid | input | 1 | A source port attempts to use the layer this cycle |
| try_port | input | ID_W | Number of the attempting port |
| try_ok | input | 1 | Destination accepted the granted send (1) or refused it (0) |
| try_hold | input | TIME_W | Occupation time in cycles for the granted attempt |
| try_grant | output | 1 | Attempt granted this cycle |
| retry_valid | output | 1 | Retry window open for the head port |
| retry_id | output | ID_W | Port invited to retry |
| pending | output | 1 | One outstanding item for draining |

## Verification
The hardest situation to reach from the ports is a retry window that goes unused while another port knocks in that same cycle. In that cycle a pop of the head and an append at the tail happen together. A later case that only a duplicate entry would disturb is also hard to reach. Directed sequences fill the list during a long occupation and let the head stay silent while a different port attempts. They then confirm which port the next window names. Seeded random traffic with short hold times and frequent destination refusals then keeps the list busy and the window contested, and a bench model of the list predicts every grant and retry.

// File: rtl/bla_pkg.sv
// Package: shared state encoding for the bus layer retry arbiter.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package bla_pkg;

    // Layer occupancy state.
    typedef enum logic [1:0] {
        LAYER_IDLE  = 2'd0,
        LAYER_BUSY  = 2'd1,
        LAYER_RETRY = 2'd2
    } layer_state_e;

endpackage

// File: rtl/bla_wait_list.sv
// Module: ordered waiting list of port numbers with a membership bitmap.
// A push of a port that is already listed, or one whose number is out of
// range, is dropped. Pop removes the head. Push and pop may share a cycle,
// and the caller guarantees they never name the same port. Depth equals
// the port count, so the list cannot overflow.
module bla_wait_list #(
    parameter int DEPTH = 4,
    parameter int ID_W  = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [ID_W-1:0]  push_id,
    input  logic             pop,
    output logic [ID_W-1:0]  head_id,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    logic [ID_W-1:0]  slot [DEPTH];
    logic [DEPTH-1:0] member;
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             in_range;
    logic             push_ok;
    logic             pop_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Decide whether the push and the pop actually take effect.
    always_comb begin
        in_range = (int'(push_id) < DEPTH);
        push_ok  = push_req && in_range && !member[push_id];
        pop_ok   = pop && !empty;
    end

    assign head_id = slot[rd_ptr];
    assign empty   = (count == '0);

    // Store pushed entries and move the pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                slot[wr_ptr] <= push_id;
                wr_ptr       <= ptr_inc(wr_ptr);
            end
            if (pop_ok)
                rd_ptr <= ptr_inc(rd_ptr);
            if (push_ok && !pop_ok)
                count <= count + 1'b1;
            else if (pop_ok && !push_ok)
                count <= count - 1'b1;
        end
    end

    // One membership bit per port: set on a push, cleared when it leaves the head.
    for (genvar g = 0; g < DEPTH; g++) begin : g_member
        always_ff @(posedge clk) begin
            if (!rst_n)
                member[g] <= 1'b0;
            else if (push_ok && int'(push_id) == g)
                member[g] <= 1'b1;
            else if (pop_ok && int'(head_id) == g)
                member[g] <= 1'b0;
        end
    end

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    a_r4_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(member) == int'(count));

endmodule

// File: rtl/bla_hold_timer.sv
// Module: down-counter for the layer occupation time.
// A load of 0 is treated as 1. The counter stops at zero. `last` marks the
// final occupied cycle.
module bla_hold_timer #(
    parameter int TIME_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] cnt,
    output logic              last
);

    assign last = (cnt == TIME_W'(1));

    // Load a new occupation or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (load_val == '0) ? TIME_W'(1) : load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/bus_layer_arbiter.sv
// Module: one layer of a shared bus with grant/refuse decisions and an ordered
// retry list.
// Assumes try_ok and try_hold are valid in the cycle of a granted attempt.
// At most one attempt is made per cycle, and port numbers are below NUM_PORTS.
module bus_layer_arbiter
    import bla_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int TIME_W    = 6,
    localparam int ID_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int CNT_W = $clog2(NUM_PORTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              try_valid,
    input  logic [ID_W-1:0]   try_port,
    input  logic              try_ok,
    input  logic [TIME_W-1:0] try_hold,
    output logic              try_grant,
    output logic              retry_valid,
    output logic [ID_W-1:0]   retry_id,
    output logic              pending
);

    layer_state_e      st, st_nxt;
    logic [ID_W-1:0]   q_head;
    logic              q_empty;
    logic [CNT_W-1:0]  q_count;
    logic              q_push, q_pop;
    logic              tmr_load, tmr_last;
    logic [TIME_W-1:0] tmr_val, tmr_cnt;
    logic              head_match;

    // Grant decision and list updates for this cycle's attempt.
    always_comb begin
        head_match = !q_empty && (try_port == q_head);
        try_grant  = try_valid &&
                     ((st == LAYER_IDLE) || (st == LAYER_RETRY && head_match));
        q_pop      = (st == LAYER_RETRY) && !(try_grant && !try_ok);
        q_push     = (try_valid && !try_grant) ||
                     (try_grant && !try_ok && st != LAYER_RETRY);
    end

    // Next layer state and the occupation timer load.
    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_val  = try_hold;
        if (try_grant) begin
            st_nxt   = LAYER_BUSY;
            tmr_load = 1'b1;
        end else begin
            unique case (st)
                LAYER_RETRY: begin
                    st_nxt   = LAYER_BUSY;
                    tmr_load = 1'b1;
                    tmr_val  = TIME_W'(1);
                end
                LAYER_BUSY: begin
                    if (tmr_last)
                        st_nxt = (!q_empty || q_push) ? LAYER_RETRY : LAYER_IDLE;
                end
                default: st_nxt = st;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= LAYER_IDLE;
        else
            st <= st_nxt;
    end

    bla_wait_list #(.DEPTH(NUM_PORTS), .ID_W(ID_W)) u_list (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (q_push),
        .push_id  (try_port),
        .pop      (q_pop),
        .head_id  (q_head),
        .empty    (q_empty),
        .count    (q_count)
    );

    bla_hold_timer #(.TIME_W(TIME_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .last     (tmr_last)
    );

    assign retry_valid = (st == LAYER_RETRY);
    assign retry_id    = q_head;
    assign pending     = (st != LAYER_IDLE) || !q_empty;

    a_r5_busy_timed: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LAYER_BUSY) |-> (tmr_cnt != '0));

    a_r8_retry_has_head: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LAYER_RETRY) |-> !q_empty);

    a_r9_window_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LAYER_RETRY) |=> (st != LAYER_RETRY));

    a_r6_head_removed: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LAYER_RETRY && try_grant && try_ok) |=>
        (int'(q_count) == int'($past(q_count)) - 1));

    a_r7_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LAYER_RETRY && try_grant && !try_ok) |=>
        (q_count == $past(q_count) && q_head == $past(q_head)));

endmodule

// File: tb/sim_bus_layer_arbiter.sv
`timescale 1ns/1ps
module sim_bus_layer_arbiter;

    localparam int NP = 4;
    localparam int IW = 2;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          try_valid = 1'b0;
    logic [IW-1:0] try_port = '0;
    logic          try_ok = 1'b0;
    logic [TW-1:0] try_hold = '0;
    logic          try_grant, retry_valid, pending;
    logic [IW-1:0] retry_id;

    int checks = 0;
    int fails  = 0;

    // Reference model state: 0 idle, 1 busy, 2 retry window.
    int m_st, m_cnt, m_len;
    int m_list [NP];

    int s_grant, s_rv, s_rid, s_pend;

    always #10 clk = ~clk;

    bus_layer_arbiter #(.NUM_PORTS(NP), .TIME_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .try_valid(try_valid), .try_port(try_port),
        .try_ok(try_ok), .try_hold(try_hold), .try_grant(try_grant),
        .retry_valid(retry_valid), .retry_id(retry_id), .pending(pending)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_grant(input int v, input int p);
        return (v != 0) && (m_st == 0 || (m_st == 2 && m_len > 0 && m_list[0] == p));
    endfunction

    function automatic int model_member(input int p);
        for (int i = 0; i < m_len; i++)
            if (m_list[i] == p) return 1;
        return 0;
    endfunction

    task automatic model_update(input int v, input int p, input int ok, input int t, input int g);
        if (m_st == 2 && !(g != 0 && ok == 0)) begin
            for (int i = 0; i < NP - 1; i++) m_list[i] = m_list[i + 1];
            m_len--;
        end
        if ((v != 0 && g == 0) || (g != 0 && ok == 0 && m_st != 2)) begin
            if (model_member(p) == 0) begin
                m_list[m_len] = p;
                m_len++;
            end
        end
        if (g != 0) begin
            m_st = 1; m_cnt = (t == 0) ? 1 : t;
        end else if (m_st == 2) begin
            m_st = 1; m_cnt = 1;
        end else if (m_st == 1) begin
            m_cnt--;
            if (m_cnt == 0) m_st = (m_len > 0) ? 2 : 0;
        end
    endtask

    task automatic step(input int v, input int p, input int ok, input int t);
        int eg;
        @(negedge clk);
        try_valid = (v != 0);
        try_port  = IW'(p);
        try_ok    = (ok != 0);
        try_hold  = TW'(t);
        #1;
        eg = model_grant(v, p);
        check("R3 grant", int'(try_grant), eg);
        check("R8 retry_valid", int'(retry_valid), int'(m_st == 2));
        if (m_st == 2) check("R8 retry_id", int'(retry_id), m_list[0]);
        check("R10 pending", int'(pending), int'(m_st != 0 || m_len != 0));
        s_grant = int'(try_grant); s_rv = int'(retry_valid);
        s_rid = int'(retry_id); s_pend = int'(pending);
        @(posedge clk);
        model_update(v, p, ok, t, eg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        m_st = 0; m_cnt = 0; m_len = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset retry_valid", int'(retry_valid), 0);
        check("R1 reset pending", int'(pending), 0);
        check("R1 reset grant", int'(try_grant), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0);
        check("R1 first cycle pending", s_pend, 0);

        // Occupation with queued refusals, duplicate refusal, silent head.
        step(1, 0, 1, 3); check("R2 idle grant", s_grant, 1);
        step(1, 1, 1, 1); check("R3 busy refuse", s_grant, 0);
        step(1, 1, 1, 1); check("R4 duplicate refuse", s_grant, 0);
        step(1, 2, 1, 1);
        step(1, 2, 1, 1); check("R8 window for head", s_rid, 1);
        check("R3 non-head refused in window", s_grant, 0);
        step(0, 0, 0, 0); check("R9 busy one cycle after drop", s_rv, 0);
        step(1, 2, 0, 2); check("R4 no second copy of port 1", s_rid, 2);
        check("R9 next head granted", s_grant, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        step(1, 2, 1, 1); check("R7 failed head stays front", s_rid, 2);
        check("R7 head regranted", s_rv, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0); check("R6 head removed, list empty", s_pend, 0);

        // Zero hold counts as one cycle.
        step(1, 3, 1, 0); check("R5 grant hold 0", s_grant, 1);
        step(0, 0, 0, 0); check("R5 busy one cycle", s_pend, 1);
        step(0, 0, 0, 0); check("R5 free after one cycle", s_pend, 0);

        // Failed non-head goes to tail.
        step(1, 1, 0, 2);
        step(1, 3, 1, 1);
        step(0, 0, 0, 0);
        step(1, 1, 1, 1); check("R7 failed sender appended first", s_rid, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0); check("R8 next window names port 3", s_rid, 3);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0); check("R9 dropped head leaves empty list", s_pend, 0);

        // Seeded random traffic checked against the model.
        for (int i = 0; i < 3000; i++) begin
            int v, p, ok, t;
            v  = ($urandom % 100) < 60;
            p  = $urandom % NP;
            ok = ($urandom % 100) < 65;
            t  = $urandom % 4;
            step(v, p, ok, t);
        end
        step(0, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule